// File: doc/BRIEF.md
# Scalar Floating-Point Data Class Tester

The block takes one IEEE 754 operand and sorts it into a data class: NaN, infinity, zero, subnormal or normal. It then tests that class against a 7-bit class mask. The operand can be a single-precision value held in binary64 layout, a binary64 value, or a binary128 value. The result is a 4-bit condition code. This code carries the operand sign, whether the class was selected by the mask, and, in single-precision mode only, a flag that says the value cannot be held exactly as a binary32 number.

Each accepted operand writes its code into one of eight 4-bit condition fields, chosen by a 3-bit index. The same code also goes into the result-class field of a 32-bit floating-point status register. That write leaves the other status bits as they were.

Operands arrive on a valid/ready input. `in_ready` is held at 1, so the block never applies back-pressure. A transfer happens on every rising clock edge where `in_valid` is 1, and the registered outputs change on that edge. The condition fields and the status register are plain state outputs with no handshake.

Top module: `fp_class_probe`

## Requirements
- R1: Mask bit 6 selects NaN of either sign. A NaN has an all-ones exponent and a nonzero fraction. NaN is tested before every other class.
- R2: Infinity comes next in priority. A positive infinity tests mask bit 5 and a negative infinity tests mask bit 4.
- R3: Zero comes after infinity. A positive zero tests mask bit 3 and a negative zero tests mask bit 2.
- R4: Subnormal is the last class tested. A positive subnormal tests mask bit 1 and a negative subnormal tests mask bit 0. A normal finite value never matches, whatever the mask.
- R5: The condition code holds LT = operand sign at bit 3, GT = 0 at bit 2, EQ = mask match at bit 1 and SO at bit 0.
- R6: When `in_valid` is 1 on a clock edge, the code is written to condition field `cr_idx`, which is `cond_out[4*cr_idx+3 : 4*cr_idx]`, and the new value is visible after that edge. The other fields keep their values. With `in_valid` at 0, neither output changes.
- R7: On the same edge, the code replaces `status_out[15:12]`. All other status bits keep their values.
- R8: The `fmt` encoding is 0 for single precision in binary64 layout, 1 for binary64 and 2 for binary128. Value 3 behaves as binary64. Modes 0, 1 and 3 read `operand[127:64]`, with the exponent in bits 126:116. Mode 2 reads the whole operand, with a 15-bit exponent in bits 126:112 and a 112-bit fraction.
- R9: In mode 0, an operand with a biased exponent from 1 to 0x380 is classed as subnormal.
- R10: In mode 0, SO is 1 exactly when the value changes on a round trip through binary32. That means: any NaN, a nonzero binary64 subnormal, an exponent above 0x47E, or a value whose significand has set bits below the binary32 precision at that exponent. Below 0x381, that precision bound is weight 2^-149.
- R11: In modes 1, 2 and 3, SO is 0.
- R12: After reset, all condition fields and the status register are 0.
- R13: `in_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand transfer request |
| in_ready | output | 1 | Always 1; the block never stalls |
| operand | input | 128 | Floating-point operand |
| class_mask | input | 7 | Class selection mask |
| fmt | input | 2 | Operand format select |
| cr_idx | input | 3 | Condition field to write |
| cond_out | output | 32 | Eight 4-bit condition fields, field i at bits 4i+3:4i |
| status_out | output | 32 | Status register, result-class field at 15:12 |

## Verification
The bench runs a set of operands through all 128 mask values: signed infinities, zeros, binary64 and binary128 subnormals, NaNs and normal numbers. This exercise separates the NaN, infinity, zero and subnormal priority and shows which bit of each sign pair is tested. Single-precision boundary values check the tiny-exponent reclassing and the round-trip flag at each edge of the exact range. These values are 2^-127, 2^-149, 2^-150, the binary32 maximum, 2^128, and values with one extra low fraction bit. Cycles with varied inputs but no valid, and a rotating field index, show that only the chosen field and the status nibble change.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    FMT_SGL = 2'd0,
    FMT_DBL = 2'd1,
    FMT_QUAD = 2'd2,
    FMT_DBL_ALT = 2'd3
  } fp_fmt_e;

  typedef struct packed {
    logic nan;
    logic inf;
    logic zero;
    logic sub;
  } fp_class_t;

  localparam int CC_W = 4;
  localparam int CC_LT = 3;
  localparam int CC_GT = 2;
  localparam int CC_EQ = 1;
  localparam int CC_SO = 0;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify #(
  parameter int EXP_W = 11,
  parameter int FRAC_W = 52,
  localparam int VAL_W = 1 + EXP_W + FRAC_W
) (
  input  logic [VAL_W-1:0] val,
  output logic sign,
  output fpc_pkg::fp_class_t cls
);
  logic [EXP_W-1:0] expo;
  logic [FRAC_W-1:0] frac;
  logic exp_max, exp_min, frac_nz;

  assign sign = val[VAL_W-1];
  assign expo = val[VAL_W-2 -: EXP_W];
  assign frac = val[FRAC_W-1:0];
  assign exp_max = &expo;
  assign exp_min = ~|expo;
  assign frac_nz = |frac;

  always_comb begin
    cls = '0;
    cls.nan = exp_max & frac_nz;
    cls.inf = exp_max & ~frac_nz;
    cls.zero = exp_min & ~frac_nz;
    cls.sub = exp_min & frac_nz;
  end
endmodule

// File: rtl/fpc_sgl_probe.sv
module fpc_sgl_probe #(
  parameter int DEXP_W = 11,
  parameter int DFRAC_W = 52,
  parameter int SFRAC_W = 23,
  parameter int TINY_MAX = 896,
  parameter int NORM_MAX = 1150,
  parameter int SUB_FLOOR = 874,
  localparam int D_W = 1 + DEXP_W + DFRAC_W,
  localparam int DROP_W = DFRAC_W - SFRAC_W,
  localparam int SUB_BASE = SUB_FLOOR + DFRAC_W,
  localparam int SH_W = $clog2(DFRAC_W + 1)
) (
  input  logic [D_W-1:0] dval,
  output logic tiny,
  output logic inexact
);
  logic [DEXP_W-1:0] expo;
  logic [DFRAC_W-1:0] frac;
  logic [SH_W-1:0] keep_sh;
  logic [DFRAC_W-1:0] low_mask;
  logic [DEXP_W-1:0] sub_dist;

  assign expo = dval[D_W-2 -: DEXP_W];
  assign frac = dval[DFRAC_W-1:0];
  assign tiny = (expo != '0) && (expo <= DEXP_W'(TINY_MAX));
  assign sub_dist = DEXP_W'(SUB_BASE) - expo;
  assign keep_sh = sub_dist[SH_W-1:0];
  assign low_mask = ~({DFRAC_W{1'b1}} << keep_sh);

  always_comb begin
    if (&expo) begin
      inexact = |frac;
    end else if (expo == '0) begin
      inexact = |frac;
    end else if (expo > DEXP_W'(NORM_MAX)) begin
      inexact = 1'b1;
    end else if (expo > DEXP_W'(TINY_MAX)) begin
      inexact = |frac[DROP_W-1:0];
    end else if (expo >= DEXP_W'(SUB_FLOOR)) begin
      inexact = |(frac & low_mask);
    end else begin
      inexact = 1'b1;
    end
  end
endmodule

// File: rtl/fpc_condgen.sv
module fpc_condgen #(
  parameter int MASK_W = 7
) (
  input  fpc_pkg::fp_class_t cls,
  input  logic sign,
  input  logic so_in,
  input  logic [MASK_W-1:0] mask,
  output logic [fpc_pkg::CC_W-1:0] cc
);
  logic hit;

  always_comb begin
    if (cls.nan) hit = mask[6];
    else if (cls.inf) hit = sign ? mask[4] : mask[5];
    else if (cls.zero) hit = sign ? mask[2] : mask[3];
    else if (cls.sub) hit = sign ? mask[0] : mask[1];
    else hit = 1'b0;
    cc = '0;
    cc[fpc_pkg::CC_LT] = sign;
    cc[fpc_pkg::CC_GT] = 1'b0;
    cc[fpc_pkg::CC_EQ] = hit;
    cc[fpc_pkg::CC_SO] = so_in;
  end
endmodule

// File: rtl/fp_class_probe.sv
module fp_class_probe #(
  parameter int OP_W = 128,
  parameter int MASK_W = 7,
  parameter int NUM_FIELDS = 8,
  parameter int STAT_W = 32,
  parameter int STAT_LSB = 12,
  localparam int IDX_W = $clog2(NUM_FIELDS),
  localparam int CC_W = fpc_pkg::CC_W,
  localparam int DBL_W = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic [OP_W-1:0] operand,
  input  logic [MASK_W-1:0] class_mask,
  input  logic [1:0] fmt,
  input  logic [IDX_W-1:0] cr_idx,
  output logic [NUM_FIELDS*CC_W-1:0] cond_out,
  output logic [STAT_W-1:0] status_out
);
  import fpc_pkg::*;

  logic dbl_sign, quad_sign, sel_sign, sel_so, sgl_tiny, sgl_inexact;
  fp_class_t dbl_cls, quad_cls, sel_cls;
  logic [CC_W-1:0] cc;
  fp_fmt_e fmt_e;
  logic [CC_W-1:0] field_q [NUM_FIELDS];
  logic [STAT_W-1:0] stat_q;

  assign in_ready = 1'b1;
  assign fmt_e = fp_fmt_e'(fmt);

  fpc_classify #(.EXP_W(11), .FRAC_W(52)) u_dbl_cls (
    .val(operand[OP_W-1 -: DBL_W]), .sign(dbl_sign), .cls(dbl_cls));

  fpc_classify #(.EXP_W(15), .FRAC_W(112)) u_quad_cls (
    .val(operand), .sign(quad_sign), .cls(quad_cls));

  fpc_sgl_probe u_sgl (
    .dval(operand[OP_W-1 -: DBL_W]), .tiny(sgl_tiny), .inexact(sgl_inexact));

  always_comb begin
    sel_cls = dbl_cls;
    sel_sign = dbl_sign;
    sel_so = 1'b0;
    case (fmt_e)
      FMT_QUAD: begin
        sel_cls = quad_cls;
        sel_sign = quad_sign;
      end
      FMT_SGL: begin
        sel_cls.sub = dbl_cls.sub | sgl_tiny;
        sel_so = sgl_inexact;
      end
      default: ;
    endcase
  end

  fpc_condgen #(.MASK_W(MASK_W)) u_cond (
    .cls(sel_cls), .sign(sel_sign), .so_in(sel_so), .mask(class_mask), .cc(cc));

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) field_q[g] <= '0;
      else if (in_valid && cr_idx == IDX_W'(g)) field_q[g] <= cc;
    end
    assign cond_out[g*CC_W +: CC_W] = field_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (in_valid) stat_q[STAT_LSB +: CC_W] <= cc;
  end
  assign status_out = stat_q;

  // R4: decoded classes never overlap
  a_r4_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_cls));
  // R11: no representability flag outside single mode
  a_r11_so_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_e != FMT_SGL) |-> !cc[CC_SO]);
  // R5: sign lands in LT
  a_r5_lt_sign: assert property (@(posedge clk) disable iff (!rst_n)
    cc[CC_LT] == operand[OP_W-1]);
  // R6: chosen field takes the code on the next edge
  a_r6_field_write: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> cond_out[$past(cr_idx)*CC_W +: CC_W] == $past(cc));
  // R6: idle cycles leave outputs alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(cond_out) && $stable(status_out));
  // R7: status nibble mirrors the written field
  a_r7_stat_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> status_out[STAT_LSB +: CC_W] == cond_out[$past(cr_idx)*CC_W +: CC_W]);
  // R7: other status bits untouched
  a_r7_stat_rest: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(status_out[STAT_W-1:STAT_LSB+CC_W]) && $stable(status_out[STAT_LSB-1:0]));
  // R13: never back-pressures
  a_r13_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

// File: tb/fp_class_probe_bench.sv
`timescale 1ns/1ps
module fp_class_probe_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] operand = '0;
  logic [6:0] class_mask = '0;
  logic [1:0] fmt = '0;
  logic [2:0] cr_idx = '0;
  logic [31:0] cond_out, status_out;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_field [8];
  logic [31:0] exp_stat;
  int q_idx[$];
  logic [3:0] q_cc[$];
  string q_tag[$];

  fp_class_probe u_fp_class_probe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .operand(operand), .class_mask(class_mask), .fmt(fmt), .cr_idx(cr_idx),
    .cond_out(cond_out), .status_out(status_out));

  always #4 clk = ~clk;

  function automatic logic [31:0] pack_fields();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) v[i*4 +: 4] = exp_field[i];
    return v;
  endfunction

  function automatic logic [3:0] ref_cc(input logic [127:0] op, input logic [6:0] m,
                                        input logic [1:0] f);
    logic s, is_nan, is_inf, is_zero, is_sub, hit, so;
    int e, ue, tz, lsb, lim;
    logic [52:0] sig;
    if (f == 2'd2) begin
      s = op[127];
      is_nan = (op[126:112] == 15'h7FFF) && (op[111:0] != 0);
      is_inf = (op[126:112] == 15'h7FFF) && (op[111:0] == 0);
      is_zero = (op[126:112] == 0) && (op[111:0] == 0);
      is_sub = (op[126:112] == 0) && (op[111:0] != 0);
      e = 0;
    end else begin
      s = op[127];
      e = int'(op[126:116]);
      is_nan = (e == 2047) && (op[115:64] != 0);
      is_inf = (e == 2047) && (op[115:64] == 0);
      is_zero = (e == 0) && (op[115:64] == 0);
      is_sub = ((e == 0) && (op[115:64] != 0)) || ((f == 2'd0) && e >= 1 && e <= 896);
    end
    if (is_nan) hit = m[6];
    else if (is_inf) hit = s ? m[4] : m[5];
    else if (is_zero) hit = s ? m[2] : m[3];
    else if (is_sub) hit = s ? m[0] : m[1];
    else hit = 1'b0;
    so = 1'b0;
    if (f == 2'd0) begin
      if (is_nan) so = 1'b1;
      else if (is_inf || is_zero) so = 1'b0;
      else if (e == 0) so = 1'b1;
      else begin
        ue = e - 1023;
        if (ue > 127) so = 1'b1;
        else begin
          sig = {1'b1, op[115:64]};
          tz = 0;
          while (sig[tz] == 1'b0) tz++;
          lsb = ue - 52 + tz;
          lim = (ue < -126) ? -149 : ue - 23;
          so = (lsb < lim);
        end
      end
    end
    return {s, 1'b0, hit, so};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [127:0] op, input logic [6:0] m, input logic [1:0] f,
                      input logic [2:0] idx, input logic [3:0] expcc, input string tag);
    @(negedge clk);
    operand = op; class_mask = m; fmt = f; cr_idx = idx; in_valid = 1'b1;
    q_idx.push_back(int'(idx)); q_cc.push_back(expcc); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sweep(input logic [127:0] op, input logic [1:0] f, input string tag);
    for (int m = 0; m < 128; m++)
      send(op, 7'(m), f, 3'(m % 8), ref_cc(op, 7'(m), f), tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (q_idx.size() > 0) begin
        int idx;
        logic [3:0] c;
        string t;
        #2;
        idx = q_idx.pop_front(); c = q_cc.pop_front(); t = q_tag.pop_front();
        exp_field[idx] = c;
        exp_stat[15:12] = c;
        check({t, " field"}, cond_out, pack_fields());
        check({t, " status R7"}, status_out, exp_stat);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] D_PINF = 64'h7FF0000000000000;
  localparam logic [63:0] D_NINF = 64'hFFF0000000000000;
  localparam logic [63:0] D_NAN = 64'h7FF8000000000000;
  localparam logic [63:0] D_NNAN = 64'hFFF0000000000001;
  localparam logic [63:0] D_NZERO = 64'h8000000000000000;
  localparam logic [63:0] D_ONE = 64'h3FF0000000000000;
  localparam logic [63:0] D_NSUB = 64'h8000000000000001;

  initial begin : stimulus
    for (int i = 0; i < 8; i++) exp_field[i] = '0;
    exp_stat = '0;
    #20;
    check("R12 reset fields", cond_out, 32'h0);
    check("R12 reset status", status_out, 32'h0);
    check("R13 ready", {31'h0, in_ready}, 32'h1);
    @(negedge clk); rst_n = 1'b1;

    // hand-computed codes: {LT,GT,EQ,SO}
    send({D_NAN, 64'h0}, 7'h40, 2'd1, 3'd0, 4'b0010, "R1 nan dbl");
    send({D_NNAN, 64'h0}, 7'h40, 2'd0, 3'd1, 4'b1011, "R1 neg nan sgl so R10");
    send({D_PINF, 64'h0}, 7'h20, 2'd1, 3'd2, 4'b0010, "R2 +inf bit5");
    send({D_NINF, 64'h0}, 7'h20, 2'd1, 3'd3, 4'b1000, "R2 -inf ignores bit5");
    send({D_NZERO, 64'h0}, 7'h04, 2'd3, 3'd4, 4'b1010, "R3 -zero bit2 fmt3 R8");
    send({D_ONE, 64'h0}, 7'h7F, 2'd1, 3'd5, 4'b0000, "R4 normal no match");
    send({D_NSUB, 64'h0}, 7'h01, 2'd1, 3'd6, 4'b1010, "R4 -sub bit0");
    send({64'h3800000000000000, 64'h0}, 7'h02, 2'd0, 3'd7, 4'b0010, "R9 tiny exp sub");
    send({64'h3800000000000000, 64'h0}, 7'h02, 2'd1, 3'd7, 4'b0000, "R9 dbl not tiny");
    send({D_ONE, 64'h0}, 7'h00, 2'd2, 3'd0, 4'b0000, "R8 quad reads 128b");
    send(128'h7FFF0000000000000000000000000000, 7'h20, 2'd2, 3'd1, 4'b0010, "R8 quad inf");
    send({64'h3FF0000000000001, 64'h0}, 7'h00, 2'd0, 3'd2, 4'b0001, "R10 low bit");
    send({64'h3FF0000010000000, 64'h0}, 7'h00, 2'd1, 3'd2, 4'b0000, "R11 dbl so clear");

    // idle cycles: inputs change without valid
    @(negedge clk);
    operand = {D_NAN, D_NAN}; class_mask = 7'h7F; fmt = 2'd0; cr_idx = 3'd0;
    repeat (3) @(negedge clk);
    check("R6 idle fields", cond_out, pack_fields());
    check("R7 idle status", status_out, exp_stat);

    // single-precision boundaries
    sweep({64'h36A0000000000000, 64'h0}, 2'd0, "R10 2^-149");
    sweep({64'h3690000000000000, 64'h0}, 2'd0, "R10 2^-150");
    sweep({64'h37F0000000000000, 64'h0}, 2'd0, "R9 2^-128");
    sweep({64'h3800000001000000, 64'h0}, 2'd0, "R10 tiny low bit");
    sweep({64'h47EFFFFFE0000000, 64'h0}, 2'd0, "R10 max sgl");
    sweep({64'h47F0000000000000, 64'h0}, 2'd0, "R10 overflow");
    sweep({64'h3810000000000000, 64'h0}, 2'd0, "R10 min normal");
    sweep({64'h0000000000000001, 64'h0}, 2'd0, "R10 dbl sub");
    sweep({D_NINF, 64'h0}, 2'd0, "R2 sgl inf");
    // main function across formats and classes
    sweep({D_NAN, 64'h0}, 2'd1, "R1 nan");
    sweep({D_NNAN, 64'h0}, 2'd3, "R1 neg nan");
    sweep({D_PINF, 64'h0}, 2'd1, "R2 +inf");
    sweep({D_NINF, 64'h0}, 2'd1, "R2 -inf");
    sweep(128'h0, 2'd1, "R3 +zero");
    sweep({D_NZERO, 64'h0}, 2'd1, "R3 -zero");
    sweep({64'h0000000000000001, 64'h0}, 2'd1, "R4 +sub");
    sweep({D_NSUB, 64'h0}, 2'd1, "R4 -sub");
    sweep({64'hC000000000000000, 64'h0}, 2'd1, "R4 -normal");
    sweep(128'h7FFF8000000000000000000000000000, 2'd2, "R8 quad nan");
    sweep(128'hFFFF0000000000000000000000000000, 2'd2, "R8 quad -inf");
    sweep(128'h80000000000000000000000000000000, 2'd2, "R8 quad -zero");
    sweep(128'h00000000000000000000000000000001, 2'd2, "R8 quad sub");
    sweep(128'h3FFF0000000000000000000000000000, 2'd2, "R8 quad normal");
    sweep({64'h3800000000000000, 64'h0}, 2'd2, "R11 quad no tiny");

    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 reset again fields", cond_out, 32'h0);
    check("R12 reset again status", status_out, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule